// File: doc/BRIEF.md
# Sigma-Delta Converter Register Access Engine

This block is the host side of a serial link to a sigma-delta converter. The converter holds a small bank of registers. Every access starts with one command byte that carries the direction and the register address, and the data bytes follow it. A requester hands the engine one operation at a time over a valid/ready handshake. The operation is a register read, a register write, a serial interface reset, or a wait-then-read. The engine drives chip select, the serial clock and the outbound data line. When the transfer ends it returns a one-cycle completion or error pulse, together with any data it read back.

The converter reuses its serial data output as a conversion-ready flag. In the wait-then-read operation the engine pulls chip select low and watches that line for a falling edge. When the edge comes it reads the result register inside the same chip-select window. If no edge arrives within a set number of cycles, the operation fails with an error. The engine also knows how many bytes each register address holds, so the requester never supplies a length. The clock divider, the clock polarity and phase, the result width, the reset length and the wait limit are all parameters.

Top module: `sdadc_regio`

## Requirements
- R1: After reset: `spi_cs_n`=1, `spi_sclk`=CPOL, `spi_mosi`=1, `req_ready`=1, and `resp_done`, `resp_err` and `rdy_evt` are all 0.
- R2: Each read or write first sends a command byte, MSB first. Bit 7 is 0. Bit 6 is 1 for a read and 0 for a write. Bits 5:3 hold `req_addr`. Bits 2:0 are 0.
- R3: The number of data bytes that follow the command depends on the address. Addresses 0, 4 and 5 take 1 byte. Addresses 1 and 2 take 2 bytes. Addresses 3, 6 and 7 take DATA_W/8 bytes. A transfer therefore gives exactly 8+8n serial clock pulses.
- R4: A write sends the low 8n bits of `req_wdata`, MSB first, right after the command byte.
- R5: A read returns the 8n received bits, assembled MSB first and zero-extended, on `resp_rdata`, together with a one-cycle `resp_done` pulse. `resp_done` and `resp_err` are never high together.
- R6: `spi_cs_n` stays low without a break from before the first clock edge until after the last one. The clock sits at its idle level CPOL whenever `spi_cs_n` is high.
- R7: The interface-reset operation (`req_op`=2) sends 32 consecutive 1 bits with chip select low, then pulses `resp_done`.
- R8: A write (`req_op`=1) to address 0, 3 or 4 produces a single `resp_err` pulse and no bus activity. Chip select stays high.
- R9: The wait-then-read operation (`req_op`=3) pulls chip select low. On a falling edge of `spi_miso` it pulses `rdy_evt`, then reads address 3 in the same chip-select window.
- R10: If `spi_miso` has no falling edge within WAIT_LIMIT cycles of a wait-then-read, the engine pulses `resp_err`, raises chip select and sends no clock.
- R11: `req_ready` is low from acceptance until the operation finishes. A request held valid while the engine is busy is accepted later and is not lost. Operation codes: 0 read, 1 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 interface reset, 3 wait then read |
| req_addr | input | 3 | Register address |
| req_wdata | input | DATA_W | Write value, right-justified |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | One-cycle error pulse |
| resp_rdata | output | DATA_W | Read value, valid with resp_done |
| rdy_evt | output | 1 | Conversion-ready edge seen |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the converter |
| spi_miso | input | 1 | Data and ready flag from the converter |

## Verification
Some properties are checked by assertions on every cycle:
- the clock stays idle while chip select is high;
- `req_ready` stays low during a bus window;
- the first bit of every command is 0, and the reset pattern holds the data line high;
- done and error never coincide;
- a ready event and an error occur only with chip select in the expected state.

The bench scenarios cover what needs a converter on the other end. They check the exact bit stream and pulse counts for each register width, the assembled read values, and the rejection of writes to read-only registers. They also cover the ready wait ending by an edge and by the timeout, and a request stalled behind a busy engine.

// File: rtl/sdadc_regio_pkg.sv
package sdadc_regio_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_IFRST  = 2'd2,
    OP_WAITRD = 2'd3
  } sd_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_SETUP, S_XFER, S_GAP
  } sd_state_e;

  localparam logic [2:0] RESULT_ADDR = 3'd3;

  // bytes following the command byte for a given register address
  function automatic int unsigned reg_bytes(input logic [2:0] a, input int unsigned wide_b);
    case (a)
      3'd1, 3'd2:       return 2;
      3'd3, 3'd6, 3'd7: return wide_b;
      default:          return 1;
    endcase
  endfunction

  function automatic logic reg_writable(input logic [2:0] a);
    return (a == 3'd1) || (a == 3'd2) || (a == 3'd5) || (a == 3'd6) || (a == 3'd7);
  endfunction

  function automatic logic [7:0] cmd_byte(input logic rd, input logic [2:0] a);
    return {1'b0, rd, a, 3'b000};
  endfunction

endpackage

// File: rtl/sdadc_tick_gen.sv
module sdadc_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
    end
  endgenerate
endmodule

// File: rtl/sdadc_bit_engine.sv
module sdadc_bit_engine #(
  parameter int SH_W  = 32,
  parameter int RX_W  = 24,
  parameter int CNT_W = 6,
  parameter bit CPOL  = 1'b1,
  parameter bit CPHA  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [SH_W-1:0]  load_tx,
  input  logic [CNT_W-1:0] load_bits,
  input  logic             force_one,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic [RX_W-1:0]  rx
);
  logic             act_q, act_d;
  logic             half_q, half_d;
  logic             frc_q, frc_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  tx_q, tx_d;
  logic [RX_W-1:0]  rx_q, rx_d;

  // bit cell: first half then second half; the half0->half1 edge samples
  // for both phases, and the outbound bit changes at the cell boundary
  always_comb begin
    act_d  = act_q;
    half_d = half_q;
    frc_d  = frc_q;
    cnt_d  = cnt_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (start && !act_q) begin
      act_d  = 1'b1;
      half_d = 1'b0;
      frc_d  = force_one;
      cnt_d  = load_bits;
      tx_d   = load_tx;
      rx_d   = '0;
    end else if (act_q && tick) begin
      if (!half_q) begin
        half_d = 1'b1;
        rx_d   = {rx_q[RX_W-2:0], miso};
      end else begin
        half_d = 1'b0;
        tx_d   = tx_q << 1;
        cnt_d  = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      frc_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      half_q <= half_d;
      frc_q  <= frc_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy = act_q;
  assign done = done_q;
  assign rx   = rx_q;
  assign sclk = act_q ? (CPOL ^ CPHA ^ half_q) : CPOL;
  assign mosi = act_q ? (frc_q | tx_q[SH_W-1]) : 1'b1;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q); // R11
endmodule

// File: rtl/sdadc_rdy_watch.sv
module sdadc_rdy_watch #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic miso,
  input  logic arm,
  output logic fall,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic          s1_q, s2_q, prev_q;
  logic [TW-1:0] wcnt_q, wcnt_d;

  assign fall    = prev_q & ~s2_q;
  assign expired = arm && (wcnt_q == TW'(LIMIT - 1));

  always_comb begin
    wcnt_d = wcnt_q;
    if (!arm)         wcnt_d = '0;
    else if (!expired) wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      wcnt_q <= '0;
    end else begin
      s1_q   <= miso;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      wcnt_q <= wcnt_d;
    end
  end
endmodule

// File: rtl/sdadc_regio.sv
module sdadc_regio
  import sdadc_regio_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int DIV        = 4,
  parameter bit CPOL       = 1'b1,
  parameter bit CPHA       = 1'b1,
  parameter int RST_BITS   = 32,
  parameter int WAIT_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [2:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_done,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              rdy_evt,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int DATA_B = DATA_W / 8;
  localparam int SH_W   = 8 + DATA_W;
  localparam int MAXB   = (SH_W > RST_BITS) ? SH_W : RST_BITS;
  localparam int CNT_W  = $clog2(MAXB + 1);
  localparam int NBW    = $clog2(DATA_B + 1);

  sd_state_e         st_q, st_d;
  sd_op_e            op_q, op_d;
  logic [2:0]        addr_q, addr_d;
  logic [NBW-1:0]    nb_q, nb_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              done_q, done_d, err_q, err_d, rdy_q, rdy_d;

  logic              tick, accept, eng_start, eng_busy, eng_done;
  logic              rdy_fall, rdy_expired;
  logic [SH_W-1:0]   load_tx;
  logic [CNT_W-1:0]  load_bits;
  logic [DATA_W-1:0] eng_rx, rx_mask, wd_aligned;

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign eng_start = (st_q == S_SETUP) && tick;

  assign wd_aligned = (op_q == OP_WRITE) ? (wdata_q << (DATA_W - 8 * int'(nb_q))) : '0;
  assign load_tx    = {cmd_byte(op_q != OP_WRITE, addr_q), wd_aligned};
  assign load_bits  = (op_q == OP_IFRST) ? CNT_W'(RST_BITS) : CNT_W'(8 + 8 * int'(nb_q));
  assign rx_mask    = ~({DATA_W{1'b1}} << (8 * int'(nb_q)));

  sdadc_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick)
  );

  sdadc_bit_engine #(
    .SH_W(SH_W), .RX_W(DATA_W), .CNT_W(CNT_W), .CPOL(CPOL), .CPHA(CPHA)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(eng_start),
    .load_tx(load_tx), .load_bits(load_bits), .force_one(op_q == OP_IFRST),
    .miso(spi_miso), .busy(eng_busy), .done(eng_done),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx(eng_rx)
  );

  sdadc_rdy_watch #(.LIMIT(WAIT_LIMIT)) u_rdy (
    .clk(clk), .rst_n(rst_n), .miso(spi_miso), .arm(st_q == S_WAIT),
    .fall(rdy_fall), .expired(rdy_expired)
  );

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    addr_d  = addr_q;
    nb_d    = nb_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    rdy_d   = 1'b0;
    unique case (st_q)
      S_IDLE: if (accept) begin
        if (sd_op_e'(req_op) == OP_WRITE && !reg_writable(req_addr)) begin
          err_d = 1'b1;
        end else if (sd_op_e'(req_op) == OP_WAITRD) begin
          op_d   = OP_READ;
          addr_d = RESULT_ADDR;
          nb_d   = NBW'(DATA_B);
          st_d   = S_WAIT;
        end else begin
          op_d    = sd_op_e'(req_op);
          addr_d  = req_addr;
          nb_d    = NBW'(reg_bytes(req_addr, DATA_B));
          wdata_d = req_wdata;
          st_d    = S_SETUP;
        end
      end
      S_WAIT: begin
        if (rdy_fall) begin
          rdy_d = 1'b1;
          st_d  = S_SETUP;
        end else if (rdy_expired) begin
          err_d = 1'b1;
          st_d  = S_GAP;
        end
      end
      S_SETUP: if (tick) st_d = S_XFER;
      S_XFER: if (eng_done) begin
        done_d = 1'b1;
        if (op_q == OP_READ) rdata_d = eng_rx & rx_mask;
        st_d = S_GAP;
      end
      S_GAP: if (tick) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      nb_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      nb_q    <= nb_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rdy_q   <= rdy_d;
    end
  end

  assign spi_cs_n   = (st_q == S_IDLE) || (st_q == S_GAP);
  assign resp_done  = done_q;
  assign resp_err   = err_q;
  assign resp_rdata = rdata_q;
  assign rdy_evt    = rdy_q;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (spi_sclk == CPOL)); // R6
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready); // R11
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_err)); // R5
  AST_CMD_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !$past(eng_busy) && op_q != OP_IFRST) |-> !spi_mosi); // R2
  AST_RST_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && op_q == OP_IFRST) |-> spi_mosi); // R7
  AST_RDY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |-> !spi_cs_n); // R9
  AST_ERR_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (spi_cs_n && !eng_busy)); // R8 R10
endmodule

// File: tb/sdadc_regio_tb.sv
module sdadc_regio_tb_top;
  localparam int DW    = 24;
  localparam int LIMIT = 200;

  logic          clk, rst_n;
  logic          req_valid, req_ready;
  logic [1:0]    req_op;
  logic [2:0]    req_addr;
  logic [DW-1:0] req_wdata;
  logic          resp_done, resp_err, rdy_evt;
  logic [DW-1:0] resp_rdata;
  logic          spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  sdadc_regio #(.DATA_W(DW), .DIV(2), .CPOL(1'b1), .CPHA(1'b1),
                .RST_BITS(32), .WAIT_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .rdy_evt(rdy_evt), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // converter model (clock idles high, drive on falling, sample on rising)
  logic [DW-1:0] regs [8];
  logic [63:0]   mosi_log;
  logic [7:0]    cmd_seen;
  logic          sl_en, sl_bit, line_lvl;
  int            bitn, edges, cs_falls, rdy_cnt, done_cnt;
  logic [DW-1:0] last_rdata;

  function automatic int nbytes(input logic [2:0] a);
    if (a == 3'd1 || a == 3'd2) return 2;
    if (a == 3'd3 || a == 3'd6 || a == 3'd7) return DW / 8;
    return 1;
  endfunction

  assign spi_miso = sl_en ? sl_bit : line_lvl;

  always @(negedge spi_cs_n) begin
    bitn = 0;
    cs_falls++;
    sl_en = 1'b0;
  end
  always @(posedge spi_cs_n) sl_en = 1'b0;

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    mosi_log = {mosi_log[62:0], spi_mosi};
    bitn++;
    edges++;
    if (bitn == 8) cmd_seen = mosi_log[7:0];
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    int nb;
    nb = nbytes(cmd_seen[5:3]);
    if (bitn >= 8 && cmd_seen[6] && bitn < 8 + 8 * nb) begin
      sl_en  = 1'b1;
      sl_bit = regs[cmd_seen[5:3]][8 * nb - 1 - (bitn - 8)];
    end else begin
      sl_en = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rdy_evt) rdy_cnt++;
    if (resp_done) begin
      done_cnt++;
      last_rdata = resp_rdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [2:0] a, input logic [DW-1:0] wd,
                         output logic d, output logic e, output logic [DW-1:0] rd);
    edges = 0;
    mosi_log = '0;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = 1'b0; e = 1'b0; rd = '0;
    for (int i = 0; i < 3000; i++) begin
      if (resp_done || resp_err) begin
        d = resp_done; e = resp_err; rd = resp_rdata;
        break;
      end
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R1 sclk idle", spi_sclk, 1);
    chk(spi_mosi == 1'b1, "R1 mosi", spi_mosi, 1);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk({resp_done, resp_err, rdy_evt} == 3'b000, "R1 pulses", {resp_done, resp_err, rdy_evt}, 0);
  endtask

  task automatic t_read(input logic [2:0] a);
    logic d, e; logic [DW-1:0] rd; int nb; logic [DW-1:0] exp;
    nb  = nbytes(a);
    exp = regs[a] & ~({DW{1'b1}} << (8 * nb));
    run_req(2'd0, a, '0, d, e, rd);
    chk(d && !e, "R5 read done", {d, e}, 2'b10);
    chk(rd == exp, "R5 read data", rd, exp);
    chk(edges == 8 + 8 * nb, "R3 read clock count", edges, 8 + 8 * nb);
    chk(mosi_log[8 + 8 * nb - 1 -: 8] == {2'b01, a, 3'b000}, "R2 read command",
        mosi_log[8 + 8 * nb - 1 -: 8], {2'b01, a, 3'b000});
  endtask

  task automatic t_write(input logic [2:0] a, input logic [DW-1:0] wd);
    logic d, e; logic [DW-1:0] rd; int nb; logic [63:0] exp; int fb;
    nb  = nbytes(a);
    fb  = cs_falls;
    exp = ({56'd0, 2'b00, a, 3'b000} << (8 * nb)) | 64'(wd & ~({DW{1'b1}} << (8 * nb)));
    run_req(2'd1, a, wd, d, e, rd);
    chk(d && !e, "R4 write done", {d, e}, 2'b10);
    chk(edges == 8 + 8 * nb, "R3 write clock count", edges, 8 + 8 * nb);
    chk((mosi_log & ~(64'hFFFF_FFFF_FFFF_FFFF << (8 + 8 * nb))) == exp, "R2 R4 write stream",
        mosi_log, exp);
    chk(cs_falls == fb + 1, "R6 single cs window", cs_falls - fb, 1);
  endtask

  task automatic t_bad_write(input logic [2:0] a);
    logic d, e; logic [DW-1:0] rd; int fb;
    fb = cs_falls;
    run_req(2'd1, a, 24'hFFFFFF, d, e, rd);
    chk(e && !d, "R8 error pulse", {d, e}, 2'b01);
    chk(edges == 0 && cs_falls == fb, "R8 no bus activity", edges, 0);
  endtask

  task automatic t_ifrst();
    logic d, e; logic [DW-1:0] rd;
    run_req(2'd2, 3'd0, '0, d, e, rd);
    chk(d && !e, "R7 reset done", {d, e}, 2'b10);
    chk(edges == 32, "R7 reset clock count", edges, 32);
    chk(mosi_log[31:0] == 32'hFFFF_FFFF, "R7 all ones", mosi_log[31:0], 32'hFFFF_FFFF);
  endtask

  task automatic t_waitrd();
    logic d; int fb, rb;
    fb = cs_falls; rb = rdy_cnt; edges = 0; d = 1'b0;
    @(negedge clk);
    req_op = 2'd3; req_addr = 3'd0; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(!spi_cs_n && edges == 0, "R9 held waiting", {spi_cs_n, 8'(edges)}, 0);
    line_lvl = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (resp_done) begin d = 1'b1; break; end
      @(negedge clk);
    end
    chk(d && resp_rdata == regs[3], "R9 result data", resp_rdata, regs[3]);
    chk(rdy_cnt == rb + 1, "R9 ready event", rdy_cnt - rb, 1);
    chk(cs_falls == fb + 1 && edges == 32, "R9 one window", {cs_falls - fb, edges}, {32'd1, 32'd32});
    repeat (4) @(negedge clk);
    line_lvl = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_timeout();
    logic d, e; logic [DW-1:0] rd; int rb;
    rb = rdy_cnt;
    run_req(2'd3, 3'd0, '0, d, e, rd);
    chk(e && !d, "R10 timeout error", {d, e}, 2'b01);
    chk(edges == 0 && spi_cs_n && rdy_cnt == rb, "R10 quiet bus", {edges, 31'd0, spi_cs_n}, 1);
  endtask

  task automatic t_stall();
    int db;
    db = done_cnt;
    @(negedge clk);
    req_op = 2'd0; req_addr = 3'd1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = 3'd2;
    chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000 && done_cnt < db + 2; i++) @(negedge clk);
    chk(done_cnt == db + 2, "R11 both completed", done_cnt - db, 2);
    chk(last_rdata == (regs[2] & 24'h00FFFF), "R11 second data", last_rdata, regs[2] & 24'h00FFFF);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    regs[0] = 24'h000088; regs[1] = 24'h00A50F; regs[2] = 24'h003C71;
    regs[3] = 24'hC3A512; regs[4] = 24'h00004B; regs[5] = 24'h000006;
    regs[6] = 24'h800001; regs[7] = 24'h5A5A5A;
    line_lvl = 1'b1; sl_en = 1'b0; sl_bit = 1'b1; cmd_seen = '0; mosi_log = '0;
    bitn = 0; edges = 0; cs_falls = 0; rdy_cnt = 0; done_cnt = 0; last_rdata = '0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(3'd4);
    t_read(3'd1);
    t_read(3'd3);
    t_read(3'd0);
    t_write(3'd2, 24'hAB1234);
    t_write(3'd7, 24'hC0FFEE);
    t_write(3'd5, 24'h000013);
    t_bad_write(3'd3);
    t_bad_write(3'd0);
    t_ifrst();
    t_waitrd();
    t_timeout();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule